// File: doc/BRIEF.md
# Store-Gather Write Buffer with Ordering Fence

This block sits between a core's store pipeline and the write port of a level-2 cache. Word-sized stores from either of the core's two hardware threads are collected into line-sized gather entries. Each entry covers one 64-byte aligned block and carries a per-byte valid mask. A complete entry leaves the buffer as a single line write that holds the full line of data together with its mask. Entries leave strictly in the order in which they were allocated. A store that lands in a block already held by an open entry is folded into that entry, and the entry keeps its place in the queue. As a result, a younger store can reach the cache before an older store to a different block.

The ordering fence is a one-cycle request. It closes every entry present at that moment, so those entries take no further merges. Stores accepted from that cycle on always open new entries behind the closed ones. Because entries drain in queue order, every store that came before the fence reaches the cache before any store that came after it. The fence reports completion with a one-cycle done pulse. The write port's ready input models a cache miss on the head entry: while ready is low, the head waits and the rest of the queue backs up behind it.

Top module: `store_gather_buf`

## Requirements
- R1: The line address of a store is st_addr[31:6]. Within the line, the byte index is st_addr[5:2]*4 + lane, where lane is the bit position in st_be. Byte k of a line travels on wr_data[8k+7:8k], and its valid flag travels on wr_mask[k].
- R2: Entries leave on the write port in the order in which they were allocated. One entry leaves in each cycle where both wr_valid and wr_ready are high, and wr_valid is high exactly when at least one entry is held.
- R3: A store whose line matches an open entry merges into that entry, which keeps its position in the queue. For example, stores to 0x1000, 0x2000 and 0x1004 produce two line writes: line 0x40 with mask 0xFF first, then line 0x80.
- R4: A merge ORs the byte enables into the entry mask, and each newly enabled byte replaces the older byte at the same position. Data bytes whose mask bit is 0 carry no meaning.
- R5: While wr_ready is low, wr_valid stays high and wr_addr does not change.
- R6: When all 8 entries are held and the incoming store matches no open entry, st_ready is low. A store that matches an open entry is still accepted. The head entry, in the cycle it leaves, does not count as a match.
- R7: A fence request closes every held entry. Every store accepted in the request cycle or later opens a new entry, even if its line equals that of an earlier entry.
- R8: bar_done pulses for one cycle, in the cycle after the last entry held at the time of the request has left. If no entry was held, the pulse comes in the cycle after the request. A request made while another is pending replaces the pending one and covers all entries held at the time of the new request.
- R9: The thread ID has no effect: stores from both threads allocate into, and merge into, the same entries.
- R10: Reset empties all entries and cancels a pending fence, so no bar_done pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store accepted when high together with st_valid |
| st_addr | input | 32 | Byte address of the word store |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Byte enables of the word |
| st_tid | input | 1 | Hardware thread that issued the store |
| bar_req | input | 1 | One-cycle ordering fence request |
| bar_done | output | 1 | One-cycle pulse when the fence has completed |
| wr_valid | output | 1 | Line write valid (head entry) |
| wr_ready | input | 1 | Cache accepts the line write; low models a miss |
| wr_addr | output | 26 | Line address of the write |
| wr_data | output | 512 | Line data |
| wr_mask | output | 64 | Per-byte valid mask of the line |

## Verification
The assertions check, on every cycle, that a stalled store implies a full queue, that a merge never grows the occupancy, that at most one open entry matches a line, that the head holds still under a miss, that a fence closes all entries, that a fence on an empty queue completes one cycle later, and that reset clears the write port. The reordering of stores to different lines, the byte-wise overwrite order within a merge, the separation of pre-fence and post-fence stores to the same line, fence completion timed to the last drain, and the irrelevance of the thread ID only show up as observed line-write sequences. The bench checks these against its queue model under directed and random stimulus.

// File: rtl/sgb_pkg.sv
package sgb_pkg;
  localparam int SGB_ENTRIES    = 8;
  localparam int SGB_LINE_BYTES = 64;
  localparam int SGB_ADDR_W     = 32;
  localparam int SGB_DATA_W     = 32;
  localparam int SGB_TID_W      = 1;
endpackage

// File: rtl/sgb_tag_match.sv
module sgb_tag_match #(
  parameter int NUM_ENT = 8,
  parameter int TAG_W   = 26,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input  logic                            en,
  input  logic [NUM_ENT-1:0]              ent_valid,
  input  logic [NUM_ENT-1:0]              ent_open,
  input  logic [NUM_ENT-1:0]              excl,
  input  logic [NUM_ENT-1:0][TAG_W-1:0]   ent_tag,
  input  logic [TAG_W-1:0]                probe,
  output logic [NUM_ENT-1:0]              hit_vec,
  output logic                            hit,
  output logic [IDX_W-1:0]                hit_idx
);
  for (genvar i = 0; i < NUM_ENT; i++) begin : g_cmp
    assign hit_vec[i] = en & ent_valid[i] & ent_open[i] & ~excl[i]
                        & (ent_tag[i] == probe);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < NUM_ENT; i++)
      if (hit_vec[i]) hit_idx = IDX_W'(i);
  end
endmodule

// File: rtl/sgb_line_store.sv
module sgb_line_store #(
  parameter int NUM_ENT    = 8,
  parameter int LINE_BYTES = 64,
  parameter int WB         = 4,
  localparam int IDX_W     = $clog2(NUM_ENT),
  localparam int WSEL_W    = $clog2(LINE_BYTES / WB),
  localparam int LINE_W    = LINE_BYTES * 8
) (
  input  logic                  clk,
  input  logic                  we,
  input  logic                  clr,
  input  logic [IDX_W-1:0]      widx,
  input  logic [WSEL_W-1:0]     wsel,
  input  logic [WB-1:0]         wbe,
  input  logic [WB*8-1:0]       wdata,
  input  logic [IDX_W-1:0]      ridx,
  output logic [LINE_W-1:0]     rdata,
  output logic [LINE_BYTES-1:0] rmask
);
  logic [LINE_W-1:0]     data_q [NUM_ENT];
  logic [LINE_BYTES-1:0] mask_q [NUM_ENT];
  logic [LINE_BYTES-1:0] be_line;

  assign be_line = {{(LINE_BYTES-WB){1'b0}}, wbe} << (int'(wsel) * WB);

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < WB; b++)
        if (wbe[b])
          data_q[widx][(int'(wsel) * WB + b) * 8 +: 8] <= wdata[b*8 +: 8];
      mask_q[widx] <= clr ? be_line : (mask_q[widx] | be_line);
    end
  end

  assign rdata = data_q[ridx];
  assign rmask = mask_q[ridx];
endmodule

// File: rtl/sgb_fence_track.sv
module sgb_fence_track #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             drain,
  input  logic [CNT_W-1:0] occ,
  output logic             done
);
  logic             busy;
  logic [CNT_W-1:0] pend, left;

  always_comb left = (req ? occ : pend) - CNT_W'(drain);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      pend <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (req || busy) begin
        pend <= left;
        if (left == '0) begin
          done <= 1'b1;
          busy <= 1'b0;
        end else begin
          busy <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/store_gather_buf.sv
module store_gather_buf import sgb_pkg::*; #(
  parameter int ADDR_W     = SGB_ADDR_W,
  parameter int DATA_W     = SGB_DATA_W,
  parameter int LINE_BYTES = SGB_LINE_BYTES,
  parameter int NUM_ENT    = SGB_ENTRIES,
  parameter int TID_W      = SGB_TID_W,
  localparam int WB        = DATA_W / 8,
  localparam int LANE_W    = $clog2(WB),
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int TAG_W     = ADDR_W - OFF_W,
  localparam int WSEL_W    = OFF_W - LANE_W,
  localparam int IDX_W     = $clog2(NUM_ENT),
  localparam int CNT_W     = $clog2(NUM_ENT + 1),
  localparam int LINE_W    = LINE_BYTES * 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  st_valid,
  output logic                  st_ready,
  input  logic [ADDR_W-1:0]     st_addr,
  input  logic [DATA_W-1:0]     st_data,
  input  logic [WB-1:0]         st_be,
  input  logic [TID_W-1:0]      st_tid,
  input  logic                  bar_req,
  output logic                  bar_done,
  output logic                  wr_valid,
  input  logic                  wr_ready,
  output logic [TAG_W-1:0]      wr_addr,
  output logic [LINE_W-1:0]     wr_data,
  output logic [LINE_BYTES-1:0] wr_mask
);
  logic [NUM_ENT-1:0]            ent_valid, ent_open, excl, hit_vec;
  logic [NUM_ENT-1:0][TAG_W-1:0] ent_tag;
  logic [IDX_W-1:0]              head, tail, hit_idx, widx;
  logic [CNT_W-1:0]              count;
  logic [TAG_W-1:0]              st_tag;
  logic                          hit, full, drain, acc, alloc;
  logic                          unused_in;

  // thread ID and sub-word address bits play no part in gathering
  assign unused_in = ^{st_tid, st_addr[LANE_W-1:0]};

  function automatic logic [IDX_W-1:0] nxt(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(NUM_ENT - 1)) ? '0 : p + 1'b1;
  endfunction

  assign st_tag   = st_addr[ADDR_W-1:OFF_W];
  assign wr_valid = ent_valid[head];
  assign wr_addr  = ent_tag[head];
  assign drain    = wr_valid & wr_ready;
  assign excl     = drain ? (NUM_ENT'(1) << head) : '0;
  assign full     = (count == CNT_W'(NUM_ENT));
  assign st_ready = hit | ~full;
  assign acc      = st_valid & st_ready;
  assign alloc    = acc & ~hit;
  assign widx     = hit ? hit_idx : tail;

  sgb_tag_match #(.NUM_ENT(NUM_ENT), .TAG_W(TAG_W)) u_match (
    .en       (st_valid & ~bar_req),
    .ent_valid(ent_valid),
    .ent_open (ent_open),
    .excl     (excl),
    .ent_tag  (ent_tag),
    .probe    (st_tag),
    .hit_vec  (hit_vec),
    .hit      (hit),
    .hit_idx  (hit_idx)
  );

  sgb_line_store #(.NUM_ENT(NUM_ENT), .LINE_BYTES(LINE_BYTES), .WB(WB)) u_lines (
    .clk  (clk),
    .we   (acc),
    .clr  (alloc),
    .widx (widx),
    .wsel (st_addr[OFF_W-1:LANE_W]),
    .wbe  (st_be),
    .wdata(st_data),
    .ridx (head),
    .rdata(wr_data),
    .rmask(wr_mask)
  );

  sgb_fence_track #(.CNT_W(CNT_W)) u_fence (
    .clk  (clk),
    .rst  (rst),
    .req  (bar_req),
    .drain(drain),
    .occ  (count),
    .done (bar_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_valid <= '0;
      ent_open  <= '0;
      head      <= '0;
      tail      <= '0;
      count     <= '0;
    end else begin
      if (drain) begin
        ent_valid[head] <= 1'b0;
        head            <= nxt(head);
      end
      if (bar_req) ent_open <= '0;
      if (alloc) begin
        ent_valid[tail] <= 1'b1;
        ent_open[tail]  <= 1'b1;
        tail            <= nxt(tail);
      end
      count <= count + CNT_W'(alloc) - CNT_W'(drain);
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) ent_tag[tail] <= st_tag;
  end
endmodule

// File: rtl/sgb_chk.sv
module sgb_chk #(
  parameter int NUM_ENT = 8,
  parameter int CNT_W   = 4,
  parameter int TAG_W   = 26
) (
  input logic               clk,
  input logic               rst,
  input logic               st_valid,
  input logic               st_ready,
  input logic               bar_req,
  input logic               bar_done,
  input logic               wr_valid,
  input logic               wr_ready,
  input logic [TAG_W-1:0]   wr_addr,
  input logic [CNT_W-1:0]   count,
  input logic [NUM_ENT-1:0] hit_vec,
  input logic [NUM_ENT-1:0] ent_open,
  input logic               acc,
  input logic               hit,
  input logic               drain
);
  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(NUM_ENT));

  a_r3_one_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  a_r3_merge_no_grow: assert property (@(posedge clk) disable iff (rst)
    (acc && hit) |=> count == $past(count) - CNT_W'($past(drain)));

  a_r5_head_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_valid && wr_addr == $past(wr_addr)));

  a_r6_stall_only_full: assert property (@(posedge clk) disable iff (rst)
    (st_valid && !st_ready) |-> count == CNT_W'(NUM_ENT));

  a_r7_fence_closes: assert property (@(posedge clk) disable iff (rst)
    (bar_req && !acc) |=> ent_open == '0);

  a_r8_idle_done: assert property (@(posedge clk) disable iff (rst)
    (bar_req && count == '0) |=> bar_done);

  a_r10_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!wr_valid && !bar_done));
endmodule

bind store_gather_buf sgb_chk #(.NUM_ENT(NUM_ENT), .CNT_W(CNT_W), .TAG_W(TAG_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .st_valid(st_valid),
  .st_ready(st_ready),
  .bar_req (bar_req),
  .bar_done(bar_done),
  .wr_valid(wr_valid),
  .wr_ready(wr_ready),
  .wr_addr (wr_addr),
  .count   (count),
  .hit_vec (hit_vec),
  .ent_open(ent_open),
  .acc     (acc),
  .hit     (hit),
  .drain   (drain)
);

// File: tb/sim_store_gather_buf.sv
module sim_store_gather_buf;
  timeunit 1ns;
  timeprecision 100ps;

  logic         clk, rst;
  logic         st_valid, st_ready, bar_req, bar_done, wr_valid, wr_ready;
  logic [31:0]  st_addr, st_data;
  logic [3:0]   st_be;
  logic [0:0]   st_tid;
  logic [25:0]  wr_addr;
  logic [511:0] wr_data;
  logic [63:0]  wr_mask;

  store_gather_buf u0 (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .st_be(st_be), .st_tid(st_tid),
    .bar_req(bar_req), .bar_done(bar_done), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // reference model: queue of gather lines
  logic [25:0]  m_tag[$];
  logic [63:0]  m_mask[$];
  logic [511:0] m_data[$];
  bit           m_open[$];
  int           m_pend;
  bit           m_busy, m_done;
  logic [25:0]  l_tag[$];
  logic [63:0]  l_mask[$];
  logic [511:0] l_data[$];
  int n_chk = 0, n_fail = 0;
  bit finished = 0, last_acc = 0, seen_done = 0;

  task automatic chk(bit ok, string req, string what, logic [511:0] act, logic [511:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [511:0] bytes_of(logic [63:0] m);
    logic [511:0] r;
    for (int k = 0; k < 64; k++) r[k*8 +: 8] = {8{m[k]}};
    return r;
  endfunction

  function automatic int find_open(bit drn);
    for (int i = (drn ? 1 : 0); i < m_tag.size(); i++)
      if (m_open[i] && m_tag[i] == st_addr[31:6]) return i;
    return -1;
  endfunction

  task automatic mmerge(int i);
    logic [511:0] d;
    logic [63:0]  m;
    d = m_data[i];
    m = m_mask[i];
    for (int b = 0; b < 4; b++)
      if (st_be[b]) begin
        int k;
        k = int'(st_addr[5:2]) * 4 + b;
        d[k*8 +: 8] = st_data[b*8 +: 8];
        m[k] = 1'b1;
      end
    m_data[i] = d;
    m_mask[i] = m;
  endtask

  // called just after a falling edge with inputs set; returns after the next falling edge
  task automatic step();
    bit drn, rdy;
    int hi;
    #1;
    if (rst) begin
      m_tag.delete(); m_mask.delete(); m_data.delete(); m_open.delete();
      m_busy = 0; m_done = 0; m_pend = 0; last_acc = 0;
      @(negedge clk);
      return;
    end
    drn = (m_tag.size() > 0) && wr_ready;
    hi  = (st_valid && !bar_req) ? find_open(drn) : -1;
    rdy = (hi >= 0) || (m_tag.size() < 8);
    chk(wr_valid == (m_tag.size() > 0), "R2", "wr_valid", wr_valid, m_tag.size() > 0);
    if (m_tag.size() > 0) begin
      chk(wr_addr == m_tag[0], "R2", "wr_addr order", wr_addr, m_tag[0]);
      chk(wr_mask == m_mask[0], "R4", "wr_mask", wr_mask, m_mask[0]);
      chk(((wr_data ^ m_data[0]) & bytes_of(m_mask[0])) == '0, "R4", "wr_data",
          wr_data & bytes_of(m_mask[0]), m_data[0] & bytes_of(m_mask[0]));
    end
    chk(st_ready == rdy, "R6", "st_ready", st_ready, rdy);
    chk(bar_done == m_done, "R8", "bar_done", bar_done, m_done);
    if (bar_done) seen_done = 1;
    // advance model
    if (drn) begin
      l_tag.push_back(m_tag[0]); l_mask.push_back(m_mask[0]); l_data.push_back(m_data[0]);
      void'(m_tag.pop_front()); void'(m_mask.pop_front());
      void'(m_data.pop_front()); void'(m_open.pop_front());
      if (hi >= 0) hi--;
    end
    m_done = 0;
    if (bar_req) begin
      foreach (m_open[i]) m_open[i] = 0;
      m_pend = m_tag.size();
      if (m_pend == 0) m_done = 1;
      m_busy = (m_pend != 0);
    end else if (m_busy && drn) begin
      m_pend--;
      if (m_pend == 0) begin m_done = 1; m_busy = 0; end
    end
    last_acc = st_valid && rdy;
    if (last_acc) begin
      if (hi < 0) begin
        m_tag.push_back(st_addr[31:6]); m_mask.push_back('0);
        m_data.push_back('0); m_open.push_back(1);
        hi = m_tag.size() - 1;
      end
      mmerge(hi);
    end
    @(negedge clk);
  endtask

  task automatic store(logic [31:0] a, logic [31:0] d, logic [3:0] be, logic [0:0] tid);
    st_valid = 1; st_addr = a; st_data = d; st_be = be; st_tid = tid;
    do step(); while (!last_acc);
    st_valid = 0;
  endtask

  task automatic flush();
    wr_ready = 1;
    while (m_tag.size() > 0) step();
    step(); step();
  endtask

  task automatic clear_log();
    l_tag.delete(); l_mask.delete(); l_data.delete(); seen_done = 0;
  endtask

  initial begin
    logic [25:0] held;
    rst = 1; st_valid = 0; st_addr = 0; st_data = 0; st_be = 0; st_tid = 0;
    bar_req = 0; wr_ready = 0;
    @(negedge clk);
    step(); step(); step();
    rst = 0;
    #1;
    chk(wr_valid == 0, "R10", "reset wr_valid", wr_valid, 0);
    chk(st_ready == 1, "R10", "reset st_ready", st_ready, 1);
    chk(bar_done == 0, "R10", "reset bar_done", bar_done, 0);
    step();

    // R3: merge keeps queue position, younger store overtakes
    clear_log(); wr_ready = 0;
    store(32'h1000, 32'h11111111, 4'hF, 0);
    store(32'h2000, 32'h22222222, 4'hF, 0);
    store(32'h1004, 32'h33333333, 4'hF, 0);
    flush();
    chk(l_tag.size() == 2, "R3", "line count", l_tag.size(), 2);
    chk(l_tag[0] == 26'h40, "R3", "first line", l_tag[0], 26'h40);
    chk(l_mask[0] == 64'hFF, "R1", "merged mask", l_mask[0], 64'hFF);
    chk(l_tag[1] == 26'h80, "R3", "second line", l_tag[1], 26'h80);

    // R1: byte placement of the top lane of word 14
    clear_log(); wr_ready = 0;
    store(32'h7038, 32'hC3000000, 4'b1000, 0);
    flush();
    chk(l_mask[0] == (64'h1 << 59), "R1", "lane mask", l_mask[0], 64'h1 << 59);
    chk(l_data[0][479:472] == 8'hC3, "R1", "lane data", l_data[0][479:472], 8'hC3);

    // R4: newer bytes overwrite older within a merge
    clear_log(); wr_ready = 0;
    store(32'h3000, 32'hAAAAAAAA, 4'hF, 0);
    store(32'h3000, 32'h55555555, 4'b0011, 1);
    flush();
    chk(l_data[0][31:0] == 32'hAAAA5555, "R4", "overwrite", l_data[0][31:0], 32'hAAAA5555);
    chk(l_mask[0] == 64'hF, "R4", "or mask", l_mask[0], 64'hF);

    // R6 / R5: full queue stalls new lines, merges still pass, head holds
    clear_log(); wr_ready = 0;
    for (int i = 0; i < 8; i++) store(32'h10000 + i * 64, i, 4'hF, 0);
    st_valid = 1; st_addr = 32'h20000; st_data = 32'h99; st_be = 4'hF;
    held = wr_addr;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(st_ready == 0, "R6", "full stall", st_ready, 0);
      step();
      chk(wr_valid && wr_addr == held, "R5", "head hold", wr_addr, held);
    end
    st_addr = 32'h10004;
    #1;
    chk(st_ready == 1, "R6", "merge while full", st_ready, 1);
    st_valid = 0;
    store(32'h10004, 32'h77, 4'hF, 0);
    wr_ready = 1;
    store(32'h20000, 32'h99, 4'hF, 0);
    flush();
    chk(l_tag.size() == 9, "R6", "lines after full", l_tag.size(), 9);

    // R7 / R8: fence separates stores to the same line
    clear_log(); wr_ready = 0;
    store(32'h5000, 32'h1, 4'hF, 0);
    bar_req = 1; step(); bar_req = 0;
    store(32'h5004, 32'h2, 4'hF, 0);
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(bar_done == 0, "R8", "done early", bar_done, 0);
      step();
    end
    flush();
    chk(l_tag.size() == 2, "R7", "fenced lines", l_tag.size(), 2);
    chk(l_mask[0] == 64'hF, "R7", "pre-fence mask", l_mask[0], 64'hF);
    chk(seen_done, "R8", "done seen", seen_done, 1);

    // R8: fence on an empty queue
    bar_req = 1; step(); bar_req = 0;
    #1;
    chk(bar_done == 1, "R8", "idle done", bar_done, 1);
    step();

    // R9: both threads merge into one entry
    clear_log(); wr_ready = 0;
    store(32'h6000, 32'hA, 4'hF, 0);
    store(32'h6004, 32'hB, 4'hF, 1);
    flush();
    chk(l_tag.size() == 1 && l_mask[0] == 64'hFF, "R9", "thread merge", l_mask[0], 64'hFF);

    // random traffic
    for (int c = 0; c < 4000; c++) begin
      if (!st_valid || last_acc) begin
        st_valid = ($urandom % 10) < 6;
        st_addr  = {20'h0, 3'($urandom % 5), 3'b0, 4'($urandom), 2'b00} + 32'h8000;
        st_data  = $urandom;
        st_be    = 4'($urandom % 15 + 1);
        st_tid   = 1'($urandom);
      end
      bar_req  = ($urandom % 20) == 0;
      wr_ready = ($urandom % 2) == 0;
      step();
    end
    st_valid = 0; bar_req = 0;
    flush();

    // R10: reset mid-flight cancels the fence
    wr_ready = 0;
    store(32'h9000, 32'h1, 4'hF, 0);
    store(32'h9040, 32'h2, 4'hF, 0);
    bar_req = 1; step(); bar_req = 0;
    rst = 1; step(); step(); rst = 0;
    wr_ready = 1;
    for (int i = 0; i < 4; i++) begin
      #1;
      chk(wr_valid == 0, "R10", "empty after reset", wr_valid, 0);
      chk(bar_done == 0, "R10", "fence cancelled", bar_done, 0);
      step();
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule